// File: doc/BRIEF.md
# I2C Register Slave with Auto-Increment Pointer

This block lets a two-wire bus master read and write a 128-entry bank of byte-wide registers. The master opens each transfer with a START. It then sends the 7-bit device address and a direction bit. A write continues with a one-byte register pointer and then any number of data bytes. A read streams bytes from the current pointer position. One pointer is shared by both directions. It moves forward by one after every data byte in either direction, so a read with no pointer byte carries on from where the last transfer stopped.

The SCL and SDA lines are oversampled in the system clock domain. SDA is driven open-drain: the block only ever pulls the line low. The bank has three regions. The two lowest entries are fixed identity bytes. The entries from 0x02 up to just below the core window are read/write storage, and each accepted write there is also announced to the core as a one-cycle strobe. The entries from 0x40 up to 0x7F are read-only and are fetched from the core through an address/data pair.

Top module: `i2c_rf_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1000011, sent MSB first. The lowest bit sets the direction: 1 means read and 0 means write.
- R2: When the address byte does not match, the block does not acknowledge it. SDA stays released for every later byte until the next START, and those bytes cause no register write.
- R3: In a write, the byte after the address loads the register pointer, and each data byte is stored at the pointer. The block acknowledges both kinds of byte by pulling SDA low during the ninth SCL pulse. Each stored byte raises `reg_wr_stb` for exactly one cycle, with `reg_wr_addr` and `reg_wr_data` valid in that cycle.
- R4: The pointer moves forward by one after every data byte, so a multi-byte write fills consecutive addresses.
- R5: A read that starts right after the address byte, with no pointer byte, returns the register at the current pointer position.
- R6: During a read, each byte is shifted out MSB first and changes only while SCL is low. The next byte follows as long as the master acknowledges. After a master NACK, SDA stays released until STOP or START.
- R7: Address 0x00 reads the version constant (0x21 by default) and address 0x01 reads 0xAC. Writes to 0x00, 0x01 and 0x40–0x7F are acknowledged but change nothing and raise no strobe.
- R8: Reads from 0x40–0x7F place the address on `core_addr` and return `core_rdata`.
- R9: After address 0x7F, the pointer wraps to 0x00 for both reads and writes.
- R10: A repeated START is accepted in any state and restarts address matching.
- R11: After reset, SDA is released, no strobe is raised, the pointer is 0x00 and all storage registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| core_addr | output | 7 | Current pointer, used as read address for the core window |
| core_rdata | input | 8 | Core byte for addresses 0x40–0x7F |
| reg_wr_stb | output | 1 | One-cycle pulse for an accepted storage write |
| reg_wr_addr | output | 7 | Address of the accepted write |
| reg_wr_data | output | 8 | Data of the accepted write |

## Verification
The hardest situations to create from the ports are the pointer wrap and the repeated START that follows a rejected address. Both require the bus engine to leave a state it otherwise stays in for a long time. The stimulus reaches the wrap by setting the pointer to 0x7E or 0x7F and then streaming enough bytes to cross it, once as a read and once as a write. It reaches the second case by sending a foreign address, clocking a further byte that must go unanswered, and then issuing a repeated START with the right address in the middle of the transfer. Write strobes are checked against a queue of expected writes, so a stray write into a protected region shows up as an unexpected entry.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,     // shifting in the address byte
        ST_SUB,     // shifting in the pointer byte
        ST_WR,      // shifting in a data byte
        ST_ACK,     // holding SDA low through the ninth pulse
        ST_RD,      // shifting out a data byte
        ST_RD_ACK,  // sampling the master's acknowledge
        ST_HOLD     // released until the next START or STOP
    } eng_state_t;

    // Per-line synchronised level and edges
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    localparam logic [6:0] DEFAULT_DEV_ADDR = 7'b1000011;
    localparam int         FIRST_RW_REG     = 2;

    // Storage region test used by the bank
    function automatic logic in_storage(input int addr, input int core_base);
        return (addr >= FIRST_RW_REG) && (addr < core_base);
    endfunction

endpackage

// File: rtl/i2c_rf_line_sync.sv
module i2c_rf_line_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output line_ev_t ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[DEPTH-2:0], line_i};
        end
    end

    always_comb begin
        ev.level = pipe[DEPTH-2];
        ev.rise  = pipe[DEPTH-2] & ~pipe[DEPTH-1];
        ev.fall  = ~pipe[DEPTH-2] & pipe[DEPTH-1];
    end

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter int         NUM_REGS = 128,
    parameter logic [6:0] DEV_ADDR = DEFAULT_DEV_ADDR,
    localparam int        AW       = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  line_ev_t      scl,
    input  line_ev_t      sda,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_REGS - 1);

    eng_state_t state, after_ack;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       master_ack;

    logic start_ev, stop_ev;
    logic [AW-1:0] ptr_next;

    assign start_ev = scl.level & sda.fall;
    assign stop_ev  = scl.level & sda.rise;
    assign ptr_next = (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            master_ack <= 1'b0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_ev) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_SUB, ST_WR: begin
                        if (scl.rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda.level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl.fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                    after_ack <= shreg[0] ? ST_RD : ST_SUB;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end else if (state == ST_SUB) begin
                                ptr       <= shreg[AW-1:0];
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= ST_WR;
                            end else begin
                                wr_stb    <= 1'b1;
                                wr_addr   <= ptr;
                                wr_data   <= shreg;
                                ptr       <= ptr_next;
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= ST_WR;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl.fall) begin
                            bit_cnt <= '0;
                            if (after_ack == ST_RD) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr_next;
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= after_ack;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl.fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_RD_ACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl.rise) begin
                            master_ack <= ~sda.level;
                        end else if (scl.fall) begin
                            if (master_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr_next;
                                state  <= ST_RD;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank
    import i2c_rf_pkg::*;
#(
    parameter int         NUM_REGS    = 128,
    parameter int         CORE_BASE   = 64,
    parameter logic [7:0] VERSION_VAL = 8'h21,
    parameter logic [7:0] ID_VAL      = 8'hAC,
    localparam int        AW          = $clog2(NUM_REGS),
    localparam int        CW          = $clog2(CORE_BASE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic [7:0]    core_rdata,
    output logic          core_wr_stb
);
    logic [7:0] regs [CORE_BASE];
    logic       wr_ok;

    assign wr_ok       = wr_stb && in_storage(int'(wr_addr), CORE_BASE);
    assign core_wr_stb = wr_ok;

    for (genvar g = 0; g < CORE_BASE; g++) begin : g_reg
        if (g == 0) begin : g_version
            assign regs[g] = VERSION_VAL;
        end else if (g == 1) begin : g_ident
            assign regs[g] = ID_VAL;
        end else begin : g_store
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_ok && wr_addr == AW'(g)) begin
                    q <= wr_data;
                end
            end
            assign regs[g] = q;
        end
    end

    always_comb begin
        if (int'(rd_addr) < CORE_BASE) begin
            rd_data = regs[rd_addr[CW-1:0]];
        end else begin
            rd_data = core_rdata;
        end
    end

endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave
    import i2c_rf_pkg::*;
#(
    parameter int         NUM_REGS    = 128,
    parameter int         CORE_BASE   = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = DEFAULT_DEV_ADDR,
    parameter logic [7:0] VERSION_VAL = 8'h21,
    parameter logic [7:0] ID_VAL      = 8'hAC,
    localparam int        AW          = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] core_addr,
    input  logic [7:0]    core_rdata,
    output logic          reg_wr_stb,
    output logic [AW-1:0] reg_wr_addr,
    output logic [7:0]    reg_wr_data
);
    line_ev_t      scl_ev, sda_ev;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;
    logic          eng_wr_stb;
    logic [AW-1:0] eng_wr_addr;
    logic [7:0]    eng_wr_data;

    i2c_rf_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .ev(scl_ev)
    );

    i2c_rf_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .ev(sda_ev)
    );

    i2c_rf_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl     (scl_ev),
        .sda     (sda_ev),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_stb  (eng_wr_stb),
        .wr_addr (eng_wr_addr),
        .wr_data (eng_wr_data),
        .sda_oe  (sda_oe)
    );

    i2c_rf_bank #(
        .NUM_REGS   (NUM_REGS),
        .CORE_BASE  (CORE_BASE),
        .VERSION_VAL(VERSION_VAL),
        .ID_VAL     (ID_VAL)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (eng_wr_stb),
        .wr_addr     (eng_wr_addr),
        .wr_data     (eng_wr_data),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .core_rdata  (core_rdata),
        .core_wr_stb (reg_wr_stb)
    );

    assign core_addr   = ptr;
    assign reg_wr_addr = eng_wr_addr;
    assign reg_wr_data = eng_wr_data;

endmodule

// File: rtl/i2c_rf_slave_chk.sv
module i2c_rf_slave_chk #(
    parameter int CORE_BASE = 64,
    parameter int AW        = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          reg_wr_stb,
    input logic [AW-1:0] reg_wr_addr
);
    // R11: SDA released in the first cycle after reset
    assert_release_after_reset_R11: assert property (@(posedge clk)
        rst |=> !sda_oe);

    // R7: strobes only ever name storage addresses
    assert_strobe_in_storage_R7: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |-> (int'(reg_wr_addr) >= 2 && int'(reg_wr_addr) < CORE_BASE));

    // R3: a strobe lasts exactly one cycle
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |=> !reg_wr_stb);

    // R3: a stored byte is acknowledged on the bus
    assert_strobe_acked_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_stb |-> sda_oe);

    // R6: the SDA drive only changes while SCL is low
    assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_rf_slave i2c_rf_slave_chk #(.CORE_BASE(CORE_BASE), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .reg_wr_stb  (reg_wr_stb),
    .reg_wr_addr (reg_wr_addr)
);

// File: tb/i2c_rf_slave_bench.sv
module i2c_rf_slave_bench;
    localparam int         Q       = 8;
    localparam logic [7:0] DEV_W   = 8'h86;
    localparam logic [7:0] DEV_R   = 8'h87;
    localparam logic [7:0] VERSION = 8'h21;

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] data;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [6:0] core_addr;
    logic [7:0] core_rdata;
    logic reg_wr_stb;
    logic [6:0] reg_wr_addr;
    logic [7:0] reg_wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    wr_item_t   exp_q[$];
    logic [7:0] shadow [128];
    logic [6:0] ptr_m = '0;

    always #5 clk = ~clk;

    assign sda_bus    = m_sda & ~sda_oe;
    assign core_rdata = {1'b0, core_addr} ^ 8'hC3;

    i2c_rf_slave u_i2c_rf_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .core_addr(core_addr), .core_rdata(core_rdata),
        .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [6:0] a);
        if (a == 7'd0) return VERSION;
        if (a == 7'd1) return 8'hAC;
        if (a < 7'd64) return shadow[a];
        return {1'b0, a} ^ 8'hC3;
    endfunction

    // Monitor: pops expected writes as strobes appear (R3, R4, R7)
    always @(negedge clk) begin
        if (!rst && reg_wr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected strobe", int'(reg_wr_addr), -1);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk(reg_wr_addr == e.addr && reg_wr_data == e.data, "R3 strobe",
                    int'({reg_wr_addr, reg_wr_data}), int'({e.addr, e.data}));
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        m_sda = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;  wait_q();
        scl = 1'b1; wait_q();
        wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        acked = !sda_bus;
        wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_q();
            scl = 1'b1; wait_q();
            b = {b[6:0], sda_bus};
            wait_q();
            scl = 1'b0; wait_q();
        end
        send_bit(ack ? 1'b0 : 1'b1);
    endtask

    // Pointer byte then data; expected strobes pushed for storage addresses
    task automatic wr_seq(input logic [6:0] sub, input logic [7:0] data[$]);
        bit a;
        logic [6:0] p;
        bus_start();
        send_byte(DEV_W, a); chk(a, "R1 write address ack", a, 1);
        send_byte({1'b0, sub}, a); chk(a, "R3 pointer ack", a, 1);
        p = sub;
        foreach (data[i]) begin
            if (p >= 7'd2 && p < 7'd64) begin
                exp_q.push_back('{addr: p, data: data[i]});
                shadow[p] = data[i];
            end
            send_byte(data[i], a); chk(a, "R3 data ack", a, 1);
            p = p + 7'd1;
        end
        bus_stop();
        ptr_m = p;
    endtask

    // Read n bytes from the pointer; optional pointer set via repeated START
    task automatic rd_seq(input bit set_ptr, input logic [6:0] sub, input int n, input string req);
        bit a;
        logic [7:0] got;
        bus_start();
        if (set_ptr) begin
            send_byte(DEV_W, a); chk(a, "R1 write address ack", a, 1);
            send_byte({1'b0, sub}, a); chk(a, "R3 pointer ack", a, 1);
            ptr_m = sub;
            bus_start();
        end
        send_byte(DEV_R, a); chk(a, "R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, got);
            chk(got == model_rd(ptr_m), req, got, model_rd(ptr_m));
            ptr_m = ptr_m + 7'd1;
        end
        chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        bit a;
        for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        chk(reg_wr_stb == 1'b0, "R11 no strobe", reg_wr_stb, 0);
        chk(core_addr == 7'd0, "R11 pointer zero", core_addr, 0);

        // R5/R11: current-address read straight after reset
        rd_seq(1'b0, 7'd0, 3, "R5 current read after reset");

        // R3: single-byte write
        wr_seq(7'h05, '{8'h3C});
        // R4: multi-byte write
        wr_seq(7'h10, '{8'h11, 8'h22, 8'h33});
        // R6/R10: sequential read via repeated START
        rd_seq(1'b1, 7'h10, 3, "R6 sequential read");
        // R5: current-address read continues at 0x13
        rd_seq(1'b0, 7'd0, 1, "R5 current read");
        rd_seq(1'b1, 7'h05, 1, "R3 read back");
        // R7: identity bytes
        rd_seq(1'b1, 7'h00, 2, "R7 identity");
        wr_seq(7'h01, '{8'h55});
        wr_seq(7'h45, '{8'h99});
        rd_seq(1'b1, 7'h01, 1, "R7 identity after write");
        // R8/R9: core window and read wrap
        rd_seq(1'b1, 7'h7E, 4, "R9 read wrap and R8 core data");
        // R9: write wrap, only 0x02 lands in storage
        wr_seq(7'h7F, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
        rd_seq(1'b1, 7'h02, 1, "R9 write wrap");

        // R2: foreign address, following byte unanswered
        bus_start();
        send_byte(8'h88, a); chk(!a, "R2 mismatch nack", a, 0);
        send_byte(8'h05, a); chk(!a, "R2 held released", a, 0);
        bus_stop();

        // R10: repeated START after mismatch
        bus_start();
        send_byte(8'h88, a); chk(!a, "R2 mismatch nack", a, 0);
        bus_start();
        send_byte(DEV_W, a); chk(a, "R10 restart address ack", a, 1);
        send_byte(8'h20, a); chk(a, "R10 pointer ack", a, 1);
        exp_q.push_back('{addr: 7'h20, data: 8'h77});
        shadow[7'h20] = 8'h77;
        send_byte(8'h77, a); chk(a, "R10 data ack", a, 1);
        bus_stop();
        rd_seq(1'b1, 7'h20, 1, "R10 read back");

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule